// File: doc/BRIEF.md
# Two-Way Timestamp Offset Calculator

This block turns the four timestamps of one two-way time exchange into a round-trip delay, a mean one-way delay and the offset of the slave clock against the master. The four instants are: master send time (t1), slave receive time (t2), slave send time (t3) and master receive time (t4). All are signed integer nanosecond values, presented one at a time on a shared bus with a sequence tag and a one-hot load strobe.

Once a full set of four timestamps sharing one sequence tag has been captured, the block registers its results and raises a single-cycle done pulse. The halved quantities carry one fractional bit, so results ending in half a nanosecond are exact. A signed static asymmetry value (forward path delay minus reverse path delay) is removed before halving. A leap-second count, given in the same units as the timestamps, converts the atomic t1 into civil time. Filtering, servo control and packet parsing belong to other blocks.

Top module: `tw_offset_calc`

## Requirements
- R1: While reset is held and after its release, done_o is 0 and rtd_o, mean_o, offset_o and civil_o are all 0 until the first done pulse.
- R2: rtd_o equals (t2 - t1) + (t4 - t3) in whole nanoseconds. This is the same as (t4 - t1) - (t3 - t2).
- R3: mean_o equals half of rtd_o. It is a two's complement value whose LSB weighs 0.5 ns. A set with t1=0, t2=5, t3=15, t4=25 gives rtd_o=15 and mean_o raw 15 (7.5 ns).
- R4: offset_o equals ((t2 - t1) - asym_i - (t4 - t3)) / 2. It is two's complement with an LSB of 0.5 ns. The set t1=0, t2=5, t3=15, t4=25 with asym_i=0 gives raw -5 (-2.5 ns).
- R5: civil_o equals t1 - leap_i, where leap_i is sampled in the cycle the result is registered.
- R6: done_o is high for exactly one cycle, in the cycle after the edge that captured the last missing timestamp of a set. t2, t3 and t4 may arrive in any order after t1.
- R7: A load of t2, t3 or t4 whose seq_i differs from the tag captured with t1 is ignored. No done pulse follows, and the stored value is not replaced.
- R8: A new t1 discards any partly captured set. Only timestamps loaded after it can complete a result.
- R9: A load of t2, t3 or t4 when no t1 is held is ignored. This includes the state after reset and after a completed set.
- R10: rtd_o, mean_o, offset_o and civil_o hold their values in every cycle in which done_o is low.
- R11: ld_i has at most one bit set. Bit 0 loads t1, bit 1 loads t2, bit 2 loads t3 and bit 3 loads t4.
- R12: No result wraps, even when every input sits at the extremes of its signed range.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_i | input | 4 | One-hot load strobe: bit k loads timestamp t(k+1) |
| seq_i | input | SEQ_W | Sequence tag of the timestamp on ts_i |
| ts_i | input | TS_W | Signed timestamp, ns |
| asym_i | input | ASYM_W | Signed static asymmetry, forward minus reverse, ns |
| leap_i | input | LEAP_W | Signed leap offset, in timestamp units |
| done_o | output | 1 | One-cycle result strobe |
| rtd_o | output | TS_W+2 | Round-trip delay, ns |
| mean_o | output | TS_W+2 | Mean one-way delay, LSB 0.5 ns |
| offset_o | output | TS_W+3 | Slave offset, LSB 0.5 ns |
| civil_o | output | TS_W+1 | Civil time of t1, ns |

## Verification
The bench sweeps every combination of the extreme and near-zero timestamp values, with several asymmetry and leap settings and every arrival order of t2 to t4. A design with sums that are too narrow would wrap at these extremes. A truncating divide would lose the half-nanosecond in odd cases. A design that applied the asymmetry with the wrong sign would miss the offset by a full asymmetry step. Directed sequences send a tag that does not match, restart with a fresh t1 partway through a set, and send stray loads with no t1 held. A design that failed to guard its capture would then raise a spurious done pulse or report values from a stale set.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int NUM_TS = 4;

  typedef enum logic [1:0] {
    TS_ORIG = 2'd0,
    TS_RECV = 2'd1,
    TS_SEND = 2'd2,
    TS_DEST = 2'd3
  } ts_idx_e;
endpackage

// File: rtl/ts_capture.sv
module ts_capture
  import tw_pkg::*;
#(
  parameter int TS_W  = 32,
  parameter int SEQ_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [NUM_TS-1:0]              ld_i,
  input  logic [SEQ_W-1:0]               seq_i,
  input  logic [TS_W-1:0]                ts_i,
  input  logic                           clear_i,
  output logic [NUM_TS-1:0][TS_W-1:0]    ts_o,
  output logic                           full_o
);
  logic [NUM_TS-1:0] have_q, have_d, wr;
  logic [SEQ_W-1:0]  seq_q;

  always_comb begin
    have_d = clear_i ? '0 : have_q;
    wr     = '0;
    if (ld_i[TS_ORIG]) begin
      // fresh origin restarts the set
      have_d = NUM_TS'(1);
      wr[TS_ORIG] = 1'b1;
    end else begin
      for (int k = 1; k < NUM_TS; k++) begin
        if (ld_i[k] && have_d[TS_ORIG] && (seq_i == seq_q)) begin
          have_d[k] = 1'b1;
          wr[k]     = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q <= '0;
      seq_q  <= '0;
    end else begin
      have_q <= have_d;
      if (wr[TS_ORIG]) seq_q <= seq_i;
    end
  end

  for (genvar g = 0; g < NUM_TS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   ts_o[g] <= '0;
      else if (wr[g]) ts_o[g] <= ts_i;
    end
  end

  assign full_o = &have_q;
endmodule

// File: rtl/tw_arith.sv
module tw_arith
  import tw_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int ASYM_W = 16,
  parameter int LEAP_W = 16
) (
  input  logic [NUM_TS-1:0][TS_W-1:0] ts_i,
  input  logic signed [ASYM_W-1:0]    asym_i,
  input  logic signed [LEAP_W-1:0]    leap_i,
  output logic signed [TS_W+1:0]      rtd_o,
  output logic signed [TS_W+2:0]      ofs2_o,
  output logic signed [TS_W:0]        civil_o
);
  localparam int SW = TS_W + 2;
  localparam int OW = TS_W + 3;
  localparam int CW = TS_W + 1;

  logic signed [TS_W-1:0] t_orig, t_recv, t_send, t_dest;
  logic signed [SW-1:0]   d_fwd, d_rev;

  assign t_orig = $signed(ts_i[TS_ORIG]);
  assign t_recv = $signed(ts_i[TS_RECV]);
  assign t_send = $signed(ts_i[TS_SEND]);
  assign t_dest = $signed(ts_i[TS_DEST]);

  assign d_fwd  = SW'(t_recv) - SW'(t_orig);
  assign d_rev  = SW'(t_dest) - SW'(t_send);
  assign rtd_o  = d_fwd + d_rev;
  // twice the offset: the Q.1 view of the halved value
  assign ofs2_o = OW'(d_fwd) - OW'(asym_i) - OW'(d_rev);
  assign civil_o = CW'(t_orig) - CW'(leap_i);
endmodule

// File: rtl/tw_offset_calc.sv
module tw_offset_calc
  import tw_pkg::*;
#(
  parameter int TS_W   = 32,
  parameter int SEQ_W  = 8,
  parameter int ASYM_W = 16,
  parameter int LEAP_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [3:0]               ld_i,
  input  logic [SEQ_W-1:0]         seq_i,
  input  logic signed [TS_W-1:0]   ts_i,
  input  logic signed [ASYM_W-1:0] asym_i,
  input  logic signed [LEAP_W-1:0] leap_i,
  output logic                     done_o,
  output logic signed [TS_W+1:0]   rtd_o,
  output logic signed [TS_W+1:0]   mean_o,
  output logic signed [TS_W+2:0]   offset_o,
  output logic signed [TS_W:0]     civil_o
);
  logic [NUM_TS-1:0][TS_W-1:0] ts_set;
  logic                        full;
  logic signed [TS_W+1:0]      rtd_c;
  logic signed [TS_W+2:0]      ofs2_c;
  logic signed [TS_W:0]        civil_c;

  ts_capture #(.TS_W(TS_W), .SEQ_W(SEQ_W)) cap_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_i   (ld_i),
    .seq_i  (seq_i),
    .ts_i   (ts_i),
    .clear_i(full),
    .ts_o   (ts_set),
    .full_o (full)
  );

  tw_arith #(.TS_W(TS_W), .ASYM_W(ASYM_W), .LEAP_W(LEAP_W)) arith_i (
    .ts_i   (ts_set),
    .asym_i (asym_i),
    .leap_i (leap_i),
    .rtd_o  (rtd_c),
    .ofs2_o (ofs2_c),
    .civil_o(civil_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      rtd_o    <= '0;
      offset_o <= '0;
      civil_o  <= '0;
    end else begin
      done_o <= full;
      if (full) begin
        rtd_o    <= rtd_c;
        offset_o <= ofs2_c;
        civil_o  <= civil_c;
      end
    end
  end

  // halving: same bits, LSB reinterpreted as 0.5 ns
  assign mean_o = rtd_o;
endmodule

// File: rtl/tw_offset_calc_chk.sv
module tw_offset_calc_chk #(
  parameter int TS_W = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [3:0]             ld_i,
  input logic                   asym_lsb_i,
  input logic                   done_o,
  input logic signed [TS_W+1:0] rtd_o,
  input logic signed [TS_W+2:0] offset_o,
  input logic signed [TS_W:0]   civil_o
);
  // R6
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R6
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(|ld_i[3:1], 2));

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(rtd_o) && $stable(offset_o) && $stable(civil_o)));

  // R4
  parity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ((rtd_o[0] ^ offset_o[0]) == $past(asym_lsb_i)));

  // R11
  onehot_ld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ld_i));
endmodule

bind tw_offset_calc tw_offset_calc_chk #(.TS_W(TS_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ld_i      (ld_i),
  .asym_lsb_i(asym_i[0]),
  .done_o    (done_o),
  .rtd_o     (rtd_o),
  .offset_o  (offset_o),
  .civil_o   (civil_o)
);

// File: tb/tw_offset_calc_tb_top.sv
module tw_offset_calc_tb_top;
  localparam int TS_W = 6, SEQ_W = 2, ASYM_W = 4, LEAP_W = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [3:0] ld_i = '0;
  logic [SEQ_W-1:0] seq_i = '0;
  logic signed [TS_W-1:0] ts_i = '0;
  logic signed [ASYM_W-1:0] asym_i = '0;
  logic signed [LEAP_W-1:0] leap_i = '0;
  logic done_o;
  logic signed [TS_W+1:0] rtd_o, mean_o;
  logic signed [TS_W+2:0] offset_o;
  logic signed [TS_W:0] civil_o;

  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tw_offset_calc #(.TS_W(TS_W), .SEQ_W(SEQ_W), .ASYM_W(ASYM_W), .LEAP_W(LEAP_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .ld_i(ld_i), .seq_i(seq_i), .ts_i(ts_i),
    .asym_i(asym_i), .leap_i(leap_i), .done_o(done_o), .rtd_o(rtd_o),
    .mean_o(mean_o), .offset_o(offset_o), .civil_o(civil_o)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic load(int idx, int val, int seq);
    ld_i  = 4'(1 << idx);
    ts_i  = TS_W'(val);
    seq_i = SEQ_W'(seq);
    @(posedge clk); #1;
    ld_i = '0;
  endtask

  // loads a set, checks the results and the pulse end
  task automatic xchg(int t1, int t2, int t3, int t4, int asym, int leap, int seq, int order);
    int tv[4];
    int p[3];
    int rtd, ofs2, civ;
    tv[0] = t1; tv[1] = t2; tv[2] = t3; tv[3] = t4;
    for (int k = 0; k < 3; k++) p[k] = 1 + ((k + order) % 3);
    if (order >= 3) begin int tmp = p[0]; p[0] = p[2]; p[2] = tmp; end
    asym_i = ASYM_W'(asym);
    leap_i = LEAP_W'(leap);
    load(0, t1, seq);
    for (int k = 0; k < 3; k++) begin
      if (k < 2) begin
        load(p[k], tv[p[k]], seq);
        check("R6 early done", int'(done_o), 0);
      end else load(p[k], tv[p[k]], seq);
    end
    rtd  = (t2 - t1) + (t4 - t3);
    ofs2 = (t2 - t1) - asym - (t4 - t3);
    civ  = t1 - leap;
    @(posedge clk); #1;
    check("R6 done", int'(done_o), 1);
    check("R2 rtd", int'(rtd_o), rtd);
    check("R3 mean", int'(mean_o), rtd);
    check("R4 offset", int'(offset_o), ofs2);
    check("R5 civil", int'(civil_o), civ);
    @(posedge clk); #1;
    check("R6 pulse end", int'(done_o), 0);
    check("R10 hold", int'(offset_o), ofs2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cv[5];
    int av[3];
    int lv[3];
    int n;
    cv[0] = -32; cv[1] = -1; cv[2] = 0; cv[3] = 1; cv[4] = 31;
    av[0] = -8; av[1] = 0; av[2] = 7;
    lv[0] = 5; lv[1] = -8; lv[2] = 7;

    repeat (3) @(posedge clk); #1;
    check("R1 done", int'(done_o), 0);
    check("R1 rtd", int'(rtd_o), 0);
    check("R1 offset", int'(offset_o), 0);
    rst_ni = 1'b1;
    @(posedge clk); #1;
    check("R1 civil", int'(civil_o), 0);

    // R9: stray loads before any origin
    load(1, 3, 0); load(2, 4, 0); load(3, 5, 0);
    @(posedge clk); #1;
    check("R9 no done", int'(done_o), 0);
    check("R9 rtd untouched", int'(rtd_o), 0);

    // worked case R3 R4
    xchg(0, 5, 15, 25, 0, 0, 1, 0);
    check("R4 worked", int'(offset_o), -5);
    check("R3 worked", int'(rtd_o), 15);

    // R7: mismatched tag ignored, stored value kept
    asym_i = '0; leap_i = '0;
    load(0, 2, 2); load(1, 9, 2);
    load(2, 20, 3);
    load(3, 30, 2);
    @(posedge clk); #1;
    check("R7 no done", int'(done_o), 0);
    load(2, 22, 3);
    @(posedge clk); #1;
    check("R7 still none", int'(done_o), 0);
    load(2, 12, 2);
    @(posedge clk); #1;
    check("R7 done", int'(done_o), 1);
    check("R7 rtd", int'(rtd_o), (9 - 2) + (30 - 12));

    // R8: new origin discards partial set
    load(0, 1, 0); load(1, 4, 0); load(2, 6, 0);
    load(0, -3, 1);
    load(3, 10, 1);
    @(posedge clk); #1;
    check("R8 no done", int'(done_o), 0);
    load(1, 8, 1); load(2, 0, 1);
    @(posedge clk); #1;
    check("R8 done", int'(done_o), 1);
    check("R8 rtd", int'(rtd_o), (8 + 3) + (10 - 0));
    check("R8 civil", int'(civil_o), -3);

    // R9: after completion, t2..t4 alone do nothing
    @(posedge clk); #1;
    load(1, 7, 1); load(2, 7, 1); load(3, 7, 1);
    @(posedge clk); #1;
    check("R9 post done", int'(done_o), 0);
    check("R9 hold", int'(rtd_o), 21);

    // R12 sweep of extremes and orders
    n = 0;
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++)
          for (int d = 0; d < 5; d++)
            for (int s = 0; s < 3; s++) begin
              xchg(cv[a], cv[b], cv[c], cv[d], av[s], lv[(s + a) % 3], n % 4, n % 6);
              n++;
            end

    // mixed values
    for (int i = 0; i < 1500; i++) begin
      xchg(int'($urandom_range(63)) - 32, int'($urandom_range(63)) - 32,
           int'($urandom_range(63)) - 32, int'($urandom_range(63)) - 32,
           int'($urandom_range(15)) - 8, int'($urandom_range(15)) - 8,
           i % 4, i % 6);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule